// File: doc/BRIEF.md
# Lockable-Address I2C Target

This block is the serial target port of a sensor conditioner. It watches the two bus wires through an oversampling system clock. Each wire passes through a synchroniser and a debounce filter. From the cleaned levels the block finds START, repeated START and STOP, and moves data one bit at a time. After a START it collects seven address bits and a direction bit. It then decides whether to answer by pulling SDA low in the ninth clock. After an answered address, bytes pass to and from the surrounding logic through a small parallel port. Each written byte arrives with a one-cycle strobe. Each byte to be read is requested with a one-cycle pulse and taken from the read-data input in that same cycle.

Address filtering is controlled by two configuration values, a 7-bit device identity and a 3-bit lock field. Only the lock value binary 011 turns filtering on. With that value the block answers only its own identity, and with any other lock value it answers every address. While the configuration inputs are marked invalid, the block uses built-in defaults: identity 0x28 with the lock code 011. SDA is driven open-drain: the block only ever produces an enable that pulls the wire low.

Top module: `i2c_lock_target`

## Requirements
- R1: After reset, sda_oe is 0 and wr_valid and rd_req are both 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes are received only after a START. A STOP releases SDA, and a byte clocked after a STOP with no new START is not acknowledged.
- R3: When the lock field equals 3'b011, the address is acknowledged only when its 7 bits equal cfg_dev_id. Acknowledge means SDA is held low through the ninth SCL pulse. After a refused address the block stays silent until the next START and produces no wr_valid.
- R4: When the lock field holds any value other than 3'b011, every 7-bit address is acknowledged.
- R5: While cfg_valid is 0, the block behaves as if the identity were 0x28 and the lock field were 3'b011.
- R6: In a write, data bytes are received MSB first. After the eighth bit of each byte, wr_valid pulses for exactly one cycle with the byte on wr_data, and the byte is acknowledged.
- R7: In a read, rd_req pulses for one cycle and rd_data is taken in that cycle. The byte is sent MSB first, and each SDA change happens only while SCL is low.
- R8: In a read, the bit that follows each byte is sampled as the controller's reply. A low bit (ACK) requests the next byte. A high bit (NACK) releases SDA, and no further rd_req occurs until the next START.
- R9: A START or STOP that arrives in the middle of a byte abandons that byte without a wr_valid. A START restarts address reception.
- R10: Any change of sda_oe while SCL is low happens within 0.5 µs after SCL fell (62 cycles of a 125 MHz clock). Apart from START and STOP handling, sda_oe does not change while SCL stays high.
- R11: A pulse on SCL or SDA that lasts fewer than DEB_CYCLES system clocks is ignored.
- R12: The eighth bit of the address byte selects the direction: 1 means read and 0 means write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL wire level |
| sda_i | input | 1 | Sampled SDA wire level |
| sda_oe | output | 1 | When 1, pulls SDA low; when 0, the wire is released |
| cfg_valid | input | 1 | 1: use cfg_dev_id and cfg_lock; 0: use the built-in defaults |
| cfg_dev_id | input | 7 | Device identity compared with the received address |
| cfg_lock | input | 3 | Lock field; 3'b011 enables address filtering |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_data | output | 8 | Received write byte |
| rd_req | output | 1 | One-cycle request for the next byte to send |
| rd_data | input | 8 | Byte to send, taken in the cycle rd_req is high |

## Verification
The bench builds the block with its default parameters, SYNC_STAGES=2 and DEB_CYCLES=4. With these values, the bench can show that a two-cycle spike on either wire is ignored, and it can measure the full path from an SCL fall to a change of sda_oe against the 62-cycle bound. The bus is first driven with a quarter bit of 32 clocks, which keeps the run short. It is then driven with 78 clocks per quarter, which is close to the 400 kHz rate. The cases covered are filtered and open addressing, the default configuration, write and read bursts, a repeated START between them, and transfers abandoned mid-byte.

// File: rtl/i2c_lock_pkg.sv
package i2c_lock_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WDATA,
    S_WACK,
    S_RLOAD,
    S_RDATA,
    S_RACK
  } tgt_state_t;

  localparam logic [2:0] LOCK_ON_CODE = 3'b011;
  localparam logic [6:0] DEF_DEV_ID   = 7'h28;
  localparam int unsigned BYTE_BITS   = 8;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;
  logic                   raw;

  assign raw = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end

  // accept a new level only after it has differed for DEB_CYCLES clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt  <= '0;
      line_out <= 1'b1;
    end else if (raw == line_out) begin
      run_cnt <= '0;
    end else if (run_cnt == CW'(DEB_CYCLES - 1)) begin
      line_out <= raw;
      run_cnt  <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (line_out != $past(line_out)) |-> ($past(raw) == line_out)) else $error("filter"); // R11

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      scl_lvl   <= 1'b1;
      sda_lvl   <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_q     <= scl_f;
      sda_q     <= sda_f;
      scl_lvl   <= scl_f;
      sda_lvl   <= sda_f;
      scl_rise  <= scl_f & ~scl_q;
      scl_fall  <= ~scl_f & scl_q;
      start_det <= scl_f & scl_q & sda_q & ~sda_f;
      stop_det  <= scl_f & scl_q & ~sda_q & sda_f;
    end
  end

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise, scl_fall, start_det, stop_det})) else $error("events"); // R2

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_lvl,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [6:0] dev_id,
  input  logic [2:0] lock,
  output logic       sda_oe,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       rd_req,
  input  logic [7:0] rd_data
);
  localparam logic [3:0] FULL = 4'(BYTE_BITS);
  localparam logic [3:0] LAST = 4'(BYTE_BITS - 1);

  tgt_state_t st;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       rnw;
  logic       mack;
  logic       addr_hit;

  assign addr_hit = (lock != LOCK_ON_CODE) || (shreg[7:1] == dev_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      rnw      <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_req   <= 1'b0;
      if (start_det) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR: begin
            if (scl_rise && cnt < FULL) begin
              shreg <= {shreg[6:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (addr_hit) begin
                sda_oe <= 1'b1;
                rnw    <= shreg[0];
                st     <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rnw) begin
                rd_req <= 1'b1;
                st     <= S_RLOAD;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_WDATA;
              end
            end
          end
          S_WDATA: begin
            if (scl_rise && cnt < FULL) begin
              shreg <= {shreg[6:0], sda_lvl};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              wr_data  <= shreg;
              wr_valid <= 1'b1;
              sda_oe   <= 1'b1;
              st       <= S_WACK;
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= S_WDATA;
            end
          end
          S_RLOAD: begin
            shreg  <= rd_data;
            sda_oe <= ~rd_data[7];
            cnt    <= '0;
            st     <= S_RDATA;
          end
          S_RDATA: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_oe <= 1'b0;
                st     <= S_RACK;
              end else begin
                sda_oe <= ~shreg[6];
                shreg  <= {shreg[6:0], 1'b0};
                cnt    <= cnt + 1'b1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                rd_req <= 1'b1;
                st     <= S_RLOAD;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !sda_oe) else $error("idle drive"); // R8
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid) else $error("wr pulse"); // R6
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req) else $error("rd pulse"); // R7
  AST_START_ABORTS: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (st == S_ADDR && !sda_oe && !wr_valid)) else $error("start"); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (st == S_IDLE && !sda_oe)) else $error("stop"); // R2
  AST_LOCK_FILTER: assert property (@(posedge clk) disable iff (rst)
    (st == S_AACK && $past(st) == S_ADDR)
      |-> ($past(lock) != LOCK_ON_CODE || shreg[7:1] == $past(dev_id))) else $error("lock"); // R3
  AST_SDA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
      |-> $stable(sda_oe)) else $error("sda hold"); // R10
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL) else $error("cnt"); // R6

endmodule

// File: rtl/i2c_lock_target.sv
module i2c_lock_target
  import i2c_lock_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         DEB_CYCLES  = 4,
  parameter logic [6:0] RST_DEV_ID  = DEF_DEV_ID,
  parameter logic [2:0] RST_LOCK    = LOCK_ON_CODE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       cfg_valid,
  input  logic [6:0] cfg_dev_id,
  input  logic [2:0] cfg_lock,
  output logic       wr_valid,
  output logic [7:0] wr_data,
  output logic       rd_req,
  input  logic [7:0] rd_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, clean_lines;
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] use_id;
  logic [2:0] use_lock;

  assign raw_lines = {sda_i, scl_i};
  assign use_id    = cfg_valid ? cfg_dev_id : RST_DEV_ID;
  assign use_lock  = cfg_valid ? cfg_lock   : RST_LOCK;

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CYCLES (DEB_CYCLES)
    ) u_filt (
      .clk     (clk),
      .rst     (rst),
      .line_in (raw_lines[g]),
      .line_out(clean_lines[g])
    );
  end

  i2c_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (clean_lines[0]),
    .sda_f    (clean_lines[1]),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_target_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .dev_id   (use_id),
    .lock     (use_lock),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_data  (rd_data)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!sda_oe && !wr_valid && !rd_req)) else $error("reset"); // R1

endmodule

// File: tb/i2c_lock_target_tb_top.sv
module i2c_lock_target_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       cfg_valid = 1'b1;
  logic [6:0] cfg_id = 7'h5A;
  logic [2:0] cfg_lock = 3'b011;
  logic [7:0] rd_data = 8'h00;
  logic       sda_oe, wr_valid, rd_req;
  logic [7:0] wr_data;
  logic       sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_lock_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .cfg_valid(cfg_valid), .cfg_dev_id(cfg_id), .cfg_lock(cfg_lock),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data)
  );

  int Q = 32;
  int n_cmp = 0, n_bad = 0, n_rdreq = 0;
  int cyc = 0, fall_at = 0, max_lat = 0, n_lat = 0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;
  logic [7:0] exp_wr[$];
  logic [7:0] rd_q[$];
  string cur_req = "R6";

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(bit b, int glitch = 0);
    sda_m = b; hold(Q); scl_m = 1'b1; hold(Q);
    if (glitch == 1) begin scl_m = 1'b0; hold(2); scl_m = 1'b1; end
    else if (glitch == 2) begin sda_m = ~b; hold(2); sda_m = b; end
    else hold(2);
    hold(Q - 2); scl_m = 1'b0; hold(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    b = sda_line; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!give_ack);
  endtask

  task automatic do_start;
    sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q); scl_m = 1'b0; hold(Q);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; hold(Q); scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(2 * Q);
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (!rst && wr_valid) begin
      if (exp_wr.size() == 0)
        check(1'b0, cur_req, "unexpected write strobe", wr_data, 0);
      else begin
        automatic logic [7:0] e = exp_wr.pop_front();
        check(wr_data == e, "R6", "write byte", wr_data, e);
      end
    end
  end

  // read data feeder
  always @(negedge clk) begin
    if (!rst && rd_req) begin
      n_rdreq++;
      rd_data = (rd_q.size() > 0) ? rd_q.pop_front() : 8'h00;
    end
  end

  // drive-latency monitor (R10)
  always @(negedge clk) begin
    if (scl_prev && !scl_m) fall_at = cyc;
    if (!rst && sda_oe != oe_prev && !scl_m) begin
      n_lat++;
      if (cyc - fall_at > max_lat) max_lat = cyc - fall_at;
    end
    scl_prev = scl_m;
    oe_prev  = sda_oe;
    cyc++;
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL all watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] d;
    int n0;
    hold(10); rst = 1'b0; hold(3);
    check(!sda_oe && !wr_valid && !rd_req, "R1", "reset outputs",
          {sda_oe, wr_valid, rd_req}, 0);
    hold(20);

    // R3 R6 R12: matching write with lock on
    cur_req = "R3";
    do_start;
    send_byte({7'h5A, 1'b0}, ack); check(ack, "R3", "matching address ack", ack, 1);
    exp_wr.push_back(8'hA5); send_byte(8'hA5, ack); check(ack, "R6", "data ack", ack, 1);
    exp_wr.push_back(8'h3C); send_byte(8'h3C, ack); check(ack, "R6", "data ack", ack, 1);
    do_stop;
    check(!sda_oe, "R2", "released after stop", sda_oe, 0);

    // R2: byte without START is ignored
    cur_req = "R2";
    scl_m = 1'b0; hold(Q);
    send_byte({7'h5A, 1'b0}, ack); check(!ack, "R2", "no ack without start", ack, 0);
    do_stop;

    // R3: mismatching address refused, following byte ignored
    cur_req = "R3";
    do_start;
    send_byte({7'h5B, 1'b0}, ack); check(!ack, "R3", "foreign address nack", ack, 0);
    send_byte(8'h55, ack); check(!ack, "R3", "byte after refusal nack", ack, 0);
    do_stop;

    // R4: lock off, any address
    cur_req = "R4";
    cfg_lock = 3'b010;
    do_start;
    send_byte({7'h13, 1'b0}, ack); check(ack, "R4", "open address 0x13", ack, 1);
    exp_wr.push_back(8'h77); send_byte(8'h77, ack);
    do_stop;
    cfg_lock = 3'b111;
    do_start;
    send_byte({7'h5B, 1'b0}, ack); check(ack, "R4", "open address 0x5B", ack, 1);
    do_stop;
    cfg_lock = 3'b011;

    // R5: defaults
    cur_req = "R5";
    cfg_valid = 1'b0;
    do_start;
    send_byte({7'h28, 1'b0}, ack); check(ack, "R5", "default address 0x28", ack, 1);
    do_stop;
    do_start;
    send_byte({7'h5A, 1'b0}, ack); check(!ack, "R5", "default lock filters 0x5A", ack, 0);
    do_stop;
    cfg_valid = 1'b1;

    // R7 R8 R12: read burst
    cur_req = "R7";
    rd_q.push_back(8'hC3); rd_q.push_back(8'h81);
    n0 = n_rdreq;
    do_start;
    send_byte({7'h5A, 1'b1}, ack); check(ack, "R12", "read address ack", ack, 1);
    recv_byte(d, 1'b1); check(d == 8'hC3, "R7", "read byte 1", d, 8'hC3);
    recv_byte(d, 1'b0); check(d == 8'h81, "R8", "read byte after ack", d, 8'h81);
    check(n_rdreq - n0 == 2, "R8", "requests in burst", n_rdreq - n0, 2);
    recv_byte(d, 1'b0); check(d == 8'hFF, "R8", "released after nack", d, 8'hFF);
    check(n_rdreq - n0 == 2, "R8", "no request after nack", n_rdreq - n0, 2);
    do_stop;

    // R9: abort by repeated START mid byte
    cur_req = "R9";
    do_start;
    send_byte({7'h5A, 1'b0}, ack);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    do_start;
    send_byte({7'h5A, 1'b0}, ack); check(ack, "R9", "address after restart", ack, 1);
    exp_wr.push_back(8'h11); send_byte(8'h11, ack);
    do_stop;
    // R9: abort by STOP mid byte
    do_start;
    send_byte({7'h5A, 1'b0}, ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    do_stop;
    check(!sda_oe && exp_wr.size() == 0, "R9", "stop mid byte", sda_oe, 0);

    // R11: glitches on both wires
    cur_req = "R11";
    do_start;
    send_byte({7'h5A, 1'b0}, ack);
    exp_wr.push_back(8'hF0);
    put_bit(1'b1, 2); put_bit(1'b1); put_bit(1'b1, 1); put_bit(1'b1);
    put_bit(1'b0); put_bit(1'b0, 1); put_bit(1'b0); put_bit(1'b0);
    get_bit(ack); check(!ack, "R11", "glitched byte ack (low)", ack, 0);
    do_stop;

    // R12 R2: write, repeated START, read
    cur_req = "R12";
    do_start;
    send_byte({7'h5A, 1'b0}, ack);
    exp_wr.push_back(8'h42); send_byte(8'h42, ack);
    do_start;
    rd_q.push_back(8'h6E);
    send_byte({7'h5A, 1'b1}, ack); check(ack, "R12", "read after restart", ack, 1);
    recv_byte(d, 1'b0); check(d == 8'h6E, "R12", "combined read", d, 8'h6E);
    do_stop;

    // R10: near 400 kHz
    cur_req = "R10";
    Q = 78;
    do_start;
    send_byte({7'h5A, 1'b0}, ack); check(ack, "R10", "ack at 400k", ack, 1);
    exp_wr.push_back(8'h9E); send_byte(8'h9E, ack);
    do_stop;
    rd_q.push_back(8'h35);
    do_start;
    send_byte({7'h5A, 1'b1}, ack);
    recv_byte(d, 1'b0); check(d == 8'h35, "R10", "read at 400k", d, 8'h35);
    do_stop;
    Q = 32;
    hold(20);

    check(n_lat > 0 && max_lat <= 62, "R10", "max SCL-fall to drive latency", max_lat, 62);
    check(exp_wr.size() == 0, "R6", "pending write bytes", exp_wr.size(), 0);
    summary();
    $finish;
  end

endmodule